// File: doc/BRIEF.md
# Multi-Master Crossbar with Address Decode

This block joins four bus masters to six slaves through one flat 32-bit address map. The masters are an instruction-fetch port (index 0), a data port (index 1), a system port (index 2) and a DMA engine (index 3). The slaves are code flash (0), boot memory (1), a tightly coupled data RAM (2), main SRAM (3), a peripheral window (4) and a system-control window (5). Each master presents a request and holds it until it sees a ready pulse. Masters that address different slaves run in the same cycle. Masters that address one slave are served in turn by a round-robin arbiter. Each slave is modelled by a stub that holds a small word memory and answers after a fixed number of wait states.

Every slave stub runs a three-state machine. In SL_IDLE it accepts a grant. SL_IDLE goes to SL_DONE when its wait count is zero, and to SL_WAIT otherwise. SL_WAIT goes to SL_DONE once the count is used up. SL_DONE always returns to SL_IDLE. Every master has an error responder with two states. ER_IDLE goes to ER_RESP when the master requests an address it may not use. ER_RESP always returns to ER_IDLE. The window at the bottom of the address map stands in for either flash or boot memory. A strap input picks which one, and the strap is latched while reset is held.

Top module: `xbar_fabric`

## Requirements
- R1: The address decode uses the top five bits. 0x0800_0000–0x0FFF_FFFF is flash, 0x1xxx_xxxx is the coupled data RAM, 0x2xxx_xxxx is SRAM, 0x4xxx_xxxx is peripherals and 0xExxx_xxxx is system control. Within a slave, address bits [5:2] pick one of 16 words.
- R2: Addresses 0x0000_0000–0x07FF_FFFF reach flash when the latched strap is 0 and boot memory when it is 1. Boot memory has no other address.
- R3: The strap is captured only while rst_n is low. Changing it after reset has no effect on the decode.
- R4: Each port can reach only certain slaves. The fetch port reaches flash and boot. The data port reaches flash, boot and the coupled RAM. The system port reaches SRAM, peripherals and system control. The DMA port reaches SRAM and peripherals.
- R5: A request to an unmapped or unreachable address raises m_ready and m_err together in the next cycle, with m_rdata zero. No slave is accessed, so a write is not stored.
- R6: A request granted in cycle t raises m_ready in cycle t+1+W. W is the wait count of the slave: flash 2, boot 1, coupled RAM 0, SRAM 1, peripherals 3, system control 1.
- R7: Masters that target different idle slaves are granted in the same cycle, and no master is served by more than one slave.
- R8: When several masters want one idle slave, exactly one is granted. Priority starts after the master granted last. After reset the lowest index wins first.
- R9: A master that loses arbitration sees m_ready low until it is granted. It keeps its request asserted.
- R10: A write stores m_wdata and returns zero read data. A read returns the word last written to that slave and index. Every word is zero after reset.
- R11: While reset is held, all m_ready and m_err outputs are low. m_err is never high without m_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | Strap that maps the low window to boot memory, latched during reset |
| m_req | input | 4 | Request per master, held until ready |
| m_we | input | 4 | Write enable per master |
| m_addr | input | 4x32 | Byte address per master |
| m_wdata | input | 4x32 | Write data per master |
| m_ready | output | 4 | Completion pulse per master |
| m_err | output | 4 | Decode error flag, valid with ready |
| m_rdata | output | 4x32 | Read data per master, valid with ready |

## Verification
Round-robin fairness is the hardest case to reach. Two masters have to contend for the same slave again and again while that slave keeps leaving and re-entering SL_IDLE. The stimulus gets there by loading back-to-back queues on the system and DMA ports, all aimed at SRAM, so that each new request lands while the other master's transfer is still completing. At the same time the fetch and data ports collide on flash. A behavioural model in the bench predicts every grant and every ready cycle. The same model also checks the alias after a change of strap without reset, and after a fresh reset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int NM      = 4;
    localparam int NS      = 6;
    localparam int AW      = 32;
    localparam int DW      = 32;
    localparam int MW      = $clog2(NM);
    localparam int WAIT_W  = 4;

    localparam int S_FLASH  = 0;
    localparam int S_BOOT   = 1;
    localparam int S_TCRAM  = 2;
    localparam int S_SRAM   = 3;
    localparam int S_PERIPH = 4;
    localparam int S_SYSCTL = 5;

    typedef enum logic [1:0] {SL_IDLE, SL_WAIT, SL_DONE} slv_state_e;
    typedef enum logic       {ER_IDLE, ER_RESP}          err_state_e;

    // hi = address bits [31:27]; result is one-hot, zero when unmapped
    function automatic logic [NS-1:0] region_of(input logic [4:0] hi, input logic boot);
        logic [NS-1:0] oh;
        oh = '0;
        case (hi[4:1])
            4'h0: begin
                if (hi[0])     oh[S_FLASH] = 1'b1;
                else if (boot) oh[S_BOOT]  = 1'b1;
                else           oh[S_FLASH] = 1'b1;
            end
            4'h1:    oh[S_TCRAM]  = 1'b1;
            4'h2:    oh[S_SRAM]   = 1'b1;
            4'h4:    oh[S_PERIPH] = 1'b1;
            4'hE:    oh[S_SYSCTL] = 1'b1;
            default: oh = '0;
        endcase
        return oh;
    endfunction
endpackage

// File: rtl/xbar_decoder.sv
module xbar_decoder
    import xbar_pkg::*;
#(
    parameter logic [NS-1:0] REACH = '1
) (
    input  logic [4:0]    addr_hi,
    input  logic          boot,
    output logic [NS-1:0] tgt,
    output logic          bad
);
    always_comb begin
        tgt = region_of(addr_hi, boot) & REACH;
        bad = ~|tgt;
    end
endmodule

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int LW = (N > 1) ? $clog2(N) : 1;

    logic [LW-1:0] last_q;
    logic [LW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = last_q;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx[LW-1:0]]) begin
                gnt[idx[LW-1:0]] = 1'b1;
                win              = idx[LW-1:0];
                found            = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_q <= LW'(N - 1);
        else if (found) last_q <= win;
    end
endmodule

// File: rtl/xbar_slave_stub.sv
module xbar_slave_stub
    import xbar_pkg::*;
#(
    parameter int unsigned WAIT  = 1,
    parameter int          WORDS = 16,
    localparam int         IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_vld,
    input  logic [MW-1:0] gnt_mst,
    input  logic [IW-1:0] req_idx,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    output logic          idle,
    output logic          done,
    output logic [MW-1:0] owner,
    output logic [DW-1:0] rdata
);
    slv_state_e state_q, state_d;

    logic [WAIT_W-1:0] cnt_q;
    logic [IW-1:0]     idx_q;
    logic              we_q;
    logic [DW-1:0]     wd_q;
    logic [DW-1:0]     mem [WORDS];
    logic              enter_done;
    logic [IW-1:0]     acc_idx;
    logic              acc_we;
    logic [DW-1:0]     acc_wd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE: if (gnt_vld) state_d = (WAIT == 0) ? SL_DONE : SL_WAIT;
            SL_WAIT: if (cnt_q == WAIT_W'(1)) state_d = SL_DONE;
            SL_DONE: state_d = SL_IDLE;
            default: state_d = SL_IDLE;
        endcase
    end

    always_comb begin
        idle       = (state_q == SL_IDLE);
        done       = (state_q == SL_DONE);
        enter_done = (state_q != SL_DONE) && (state_d == SL_DONE);
        acc_idx    = idle ? req_idx   : idx_q;
        acc_we     = idle ? req_we    : we_q;
        acc_wd     = idle ? req_wdata : wd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
            owner <= '0;
            rdata <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (idle && gnt_vld) begin
                owner <= gnt_mst;
                idx_q <= req_idx;
                we_q  <= req_we;
                wd_q  <= req_wdata;
                cnt_q <= WAIT_W'(WAIT);
            end else if (state_q == SL_WAIT) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (enter_done) begin
                if (acc_we) begin
                    mem[acc_idx] <= acc_wd;
                    rdata        <= '0;
                end else begin
                    rdata <= mem[acc_idx];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_err_responder.sv
module xbar_err_responder
    import xbar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic bad,
    output logic resp
);
    err_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ER_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ER_IDLE: if (req && bad) state_d = ER_RESP;
            ER_RESP: state_d = ER_IDLE;
            default: state_d = ER_IDLE;
        endcase
    end

    always_comb resp = (state_q == ER_RESP);
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
    import xbar_pkg::*;
#(
    parameter int                  MEM_WORDS = 16,
    parameter logic [NS*WAIT_W-1:0] SLV_WAITS = 24'h131012,
    parameter logic [NM*NS-1:0]     MST_REACH = 24'h6381C3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boot_sel,
    input  logic [NM-1:0]          m_req,
    input  logic [NM-1:0]          m_we,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0][DW-1:0]  m_wdata,
    output logic [NM-1:0]          m_ready,
    output logic [NM-1:0]          m_err,
    output logic [NM-1:0][DW-1:0]  m_rdata
);
    localparam int IW = $clog2(MEM_WORDS);

    logic                    boot_q;
    logic [NM-1:0][NS-1:0]   tgt;
    logic [NM-1:0]           bad;
    logic [NM-1:0]           err_resp;
    logic [NS-1:0][NM-1:0]   arb_req;
    logic [NS-1:0][NM-1:0]   slv_gnt;
    logic [NS-1:0][NM-1:0]   slv_own_busy;
    logic [NS-1:0]           slv_idle;
    logic [NS-1:0]           slv_done;
    logic [NS-1:0][MW-1:0]   slv_own;
    logic [NS-1:0][DW-1:0]   slv_rd;
    logic                    unused_addr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= boot_sel;
    end

    always_comb begin
        unused_addr_bits = 1'b0;
        for (int m = 0; m < NM; m++)
            unused_addr_bits ^= ^{m_addr[m][26:IW+2], m_addr[m][1:0]};
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
        xbar_decoder #(.REACH(MST_REACH[m*NS +: NS])) u_dec (
            .addr_hi (m_addr[m][31:27]),
            .boot    (boot_q),
            .tgt     (tgt[m]),
            .bad     (bad[m])
        );
        xbar_err_responder u_err (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (m_req[m]),
            .bad   (bad[m]),
            .resp  (err_resp[m])
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        logic [MW-1:0] g_mst;
        logic [IW-1:0] g_idx;
        logic          g_we;
        logic [DW-1:0] g_wd;

        always_comb begin
            for (int m = 0; m < NM; m++)
                arb_req[s][m] = m_req[m] & tgt[m][s] & slv_idle[s];
        end

        xbar_rr_arbiter #(.N(NM)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (arb_req[s]),
            .gnt   (slv_gnt[s])
        );

        always_comb begin
            g_mst = '0;
            g_idx = '0;
            g_we  = 1'b0;
            g_wd  = '0;
            for (int m = 0; m < NM; m++) begin
                if (slv_gnt[s][m]) begin
                    g_mst = MW'(m);
                    g_idx = m_addr[m][IW+1:2];
                    g_we  = m_we[m];
                    g_wd  = m_wdata[m];
                end
            end
        end

        xbar_slave_stub #(
            .WAIT  (int'(SLV_WAITS[s*WAIT_W +: WAIT_W])),
            .WORDS (MEM_WORDS)
        ) u_stub (
            .clk       (clk),
            .rst_n     (rst_n),
            .gnt_vld   (|slv_gnt[s]),
            .gnt_mst   (g_mst),
            .req_idx   (g_idx),
            .req_we    (g_we),
            .req_wdata (g_wd),
            .idle      (slv_idle[s]),
            .done      (slv_done[s]),
            .owner     (slv_own[s]),
            .rdata     (slv_rd[s])
        );

        always_comb begin
            for (int m = 0; m < NM; m++)
                slv_own_busy[s][m] = !slv_idle[s] && (slv_own[s] == MW'(m));
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_ready[m] = err_resp[m];
            m_err[m]   = err_resp[m];
            m_rdata[m] = '0;
            for (int s = 0; s < NS; s++) begin
                if (slv_done[s] && slv_own[s] == MW'(m)) begin
                    m_ready[m] = 1'b1;
                    m_rdata[m] = m_rdata[m] | slv_rd[s];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_fabric_chk.sv
module xbar_fabric_chk
    import xbar_pkg::*;
#(
    parameter logic [NS*WAIT_W-1:0] SLV_WAITS = 24'h131012
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NM-1:0]         m_req,
    input logic [NM-1:0]         m_ready,
    input logic [NM-1:0]         m_err,
    input logic                  boot_q,
    input logic [NS-1:0][NM-1:0] slv_gnt,
    input logic [NS-1:0][NM-1:0] arb_req,
    input logic [NS-1:0][NM-1:0] slv_own_busy
);
    assert_boot_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(boot_q));

    for (genvar s = 0; s < NS; s++) begin : g_s
        assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(slv_gnt[s]));
        for (genvar m = 0; m < NM; m++) begin : g_m
            assert_loser_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (arb_req[s][m] && !slv_gnt[s][m]) |=> !m_ready[m]);
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mc
        logic [NS-1:0] col;
        for (genvar s = 0; s < NS; s++) begin : g_col
            assign col[s] = slv_own_busy[s][m];
        end
        assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
        assert_err_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
            m_err[m] |-> m_ready[m]);
        assert_err_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
            m_err[m] |-> $past(m_req[m]));
    end

    if (SLV_WAITS[S_TCRAM*WAIT_W +: WAIT_W] == '0) begin : g_tc
        assert_tcram_zero_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (|slv_gnt[S_TCRAM]) |=> m_ready[1]);
    end
endmodule

bind xbar_fabric xbar_fabric_chk #(.SLV_WAITS(SLV_WAITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_req        (m_req),
    .m_ready      (m_ready),
    .m_err        (m_err),
    .boot_q       (boot_q),
    .slv_gnt      (slv_gnt),
    .arb_req      (arb_req),
    .slv_own_busy (slv_own_busy)
);

// File: tb/tb_xbar_fabric.sv
module tb_xbar_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int NS = 6;

    typedef struct {
        logic [31:0] a;
        bit          we;
        logic [31:0] d;
    } txn_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  boot_sel = 1'b0;
    logic [NM-1:0]         req = '0;
    logic [NM-1:0]         we = '0;
    logic [NM-1:0][31:0]   addr = '0;
    logic [NM-1:0][31:0]   wd = '0;
    logic [NM-1:0]         rdy;
    logic [NM-1:0]         err;
    logic [NM-1:0][31:0]   rd;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R11";

    xbar_fabric dut (
        .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
        .m_req(req), .m_we(we), .m_addr(addr), .m_wdata(wd),
        .m_ready(rdy), .m_err(err), .m_rdata(rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    txn_t        q[NM][$];
    txn_t        cur[NM];
    bit          act[NM];
    bit          boot_m;
    int          ph[NS];      // 0 idle, 1 waiting, 2 answering
    int          cnt[NS];
    int          own[NS];
    int          last[NS];
    txn_t        held[NS];
    logic [31:0] mem[NS][16];
    bit          ep[NM];
    bit          exp_rdy[NM];
    bit          exp_err[NM];
    logic [31:0] exp_rd[NM];
    int          waits[NS] = '{2, 1, 0, 1, 3, 1};

    function automatic bit reach(int m, int s);
        case (m)
            0: return (s == 0 || s == 1);
            1: return (s == 0 || s == 1 || s == 2);
            2: return (s == 3 || s == 4 || s == 5);
            default: return (s == 3 || s == 4);
        endcase
    endfunction

    function automatic int target(int m, logic [31:0] a);
        int s;
        if (a < 32'h0800_0000)      s = boot_m ? 1 : 0;
        else if (a < 32'h1000_0000) s = 0;
        else if (a < 32'h2000_0000) s = 2;
        else if (a < 32'h3000_0000) s = 3;
        else if (a >= 32'h4000_0000 && a < 32'h5000_0000) s = 4;
        else if (a >= 32'hE000_0000 && a < 32'hF000_0000) s = 5;
        else return -1;
        return reach(m, s) ? s : -1;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < NS; s++) begin
            ph[s] = 0; cnt[s] = 0; own[s] = 0; last[s] = NM - 1;
            for (int i = 0; i < 16; i++) mem[s][i] = '0;
        end
        for (int m = 0; m < NM; m++) begin
            ep[m] = 0; exp_rdy[m] = 0; exp_err[m] = 0; exp_rd[m] = '0; act[m] = 0;
            q[m].delete();
        end
        boot_m = boot_sel;
    endfunction

    function automatic void finish_slave(int s, ref bit nr[NM], ref logic [31:0] nd[NM]);
        int i;
        i = int'(held[s].a[5:2]);
        nr[own[s]] = 1;
        if (held[s].we) begin
            mem[s][i] = held[s].d;
            nd[own[s]] = '0;
        end else begin
            nd[own[s]] = mem[s][i];
        end
    endfunction

    function automatic void model_step();
        bit          nr[NM];
        bit          ne[NM];
        logic [31:0] nd[NM];
        for (int m = 0; m < NM; m++) begin nr[m] = 0; ne[m] = 0; nd[m] = '0; end
        for (int s = 0; s < NS; s++) begin
            if (ph[s] == 2) ph[s] = 0;
            else if (ph[s] == 1) begin
                cnt[s]--;
                if (cnt[s] == 0) begin ph[s] = 2; finish_slave(s, nr, nd); end
            end else begin
                for (int k = 1; k <= NM; k++) begin
                    int m;
                    m = (last[s] + k) % NM;
                    if (ph[s] == 0 && act[m] && target(m, cur[m].a) == s) begin
                        own[s] = m; last[s] = m; held[s] = cur[m];
                        if (waits[s] == 0) begin ph[s] = 2; finish_slave(s, nr, nd); end
                        else begin ph[s] = 1; cnt[s] = waits[s]; end
                    end
                end
            end
        end
        for (int m = 0; m < NM; m++) begin
            if (ep[m]) ep[m] = 0;
            else if (act[m] && target(m, cur[m].a) < 0) begin
                ep[m] = 1; nr[m] = 1; ne[m] = 1;
            end
        end
        for (int m = 0; m < NM; m++) begin
            exp_rdy[m] = nr[m]; exp_err[m] = ne[m]; exp_rd[m] = nd[m];
        end
    endfunction

    task automatic cycle_step();
        for (int m = 0; m < NM; m++) begin
            checks++;
            if (rdy[m] !== exp_rdy[m] || err[m] !== exp_err[m] ||
                (exp_rdy[m] && rd[m] !== exp_rd[m])) begin
                errors++;
                $display("FAIL %s master %0d: ready=%b err=%b rdata=%h expected ready=%b err=%b rdata=%h",
                         cur_tag, m, rdy[m], err[m], rd[m], exp_rdy[m], exp_err[m], exp_rd[m]);
            end
        end
        for (int m = 0; m < NM; m++) begin
            if (act[m] && exp_rdy[m]) act[m] = 0;
            if (!act[m] && q[m].size() > 0) begin
                cur[m] = q[m].pop_front();
                act[m] = 1;
            end
            req[m]  = act[m];
            we[m]   = act[m] ? cur[m].we : 1'b0;
            addr[m] = act[m] ? cur[m].a  : '0;
            wd[m]   = act[m] ? cur[m].d  : '0;
        end
        model_step();
    endtask

    function automatic bit pending();
        for (int m = 0; m < NM; m++) if (act[m] || q[m].size() > 0 || ep[m]) return 1;
        for (int s = 0; s < NS; s++) if (ph[s] != 0) return 1;
        return 0;
    endfunction

    task automatic put(int m, logic [31:0] a, bit w, logic [31:0] d);
        txn_t t;
        t.a = a; t.we = w; t.d = d;
        q[m].push_back(t);
    endtask

    task automatic run_phase(string tag);
        int guard = 0;
        cur_tag = tag;
        while (pending() && guard < 2000) begin
            @(negedge clk);
            cycle_step();
            guard++;
        end
        @(negedge clk);
        cycle_step();
        if (guard >= 2000) begin
            errors++; checks++;
            $display("FAIL %s phase hung: pending=1 expected pending=0", tag);
        end
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        boot_sel = strap;
        req = '0; we = '0; addr = '0; wd = '0;
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (rdy !== '0 || err !== '0) begin   // R11 reset state
            errors++;
            $display("FAIL R11 in reset: ready=%b err=%b expected ready=0000 err=0000", rdy, err);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired: done=0 expected done=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset(1'b0);

        // R1 R10: decode of every region and read-after-write
        put(1, 32'h0800_0010, 1, 32'hA1A1_0001);
        put(1, 32'h1000_0004, 1, 32'hB2B2_0002);
        put(1, 32'h0800_0010, 0, 0);
        put(1, 32'h1000_0004, 0, 0);
        put(1, 32'h1000_0008, 0, 0);
        put(2, 32'h2000_0008, 1, 32'hC3C3_0003);
        put(2, 32'h4000_000C, 1, 32'hD4D4_0004);
        put(2, 32'hE000_0000, 1, 32'hE5E5_0005);
        put(2, 32'h2000_0008, 0, 0);
        put(2, 32'h4000_000C, 0, 0);
        put(2, 32'hE000_0000, 0, 0);
        run_phase("R1 R10");

        // R2: alias to flash with strap low
        put(1, 32'h0800_0020, 1, 32'h1234_5678);
        put(0, 32'h0000_0020, 0, 0);
        put(0, 32'h0800_0020, 0, 0);
        run_phase("R2");

        // R3: strap change without reset has no effect
        @(negedge clk);
        boot_sel = 1'b1;
        put(0, 32'h0000_0020, 0, 0);
        put(1, 32'h0000_0010, 0, 0);
        run_phase("R3");

        // R2: reset with strap high maps the window to boot memory
        do_reset(1'b1);
        put(1, 32'h0000_0004, 1, 32'hB00B_0001);
        put(1, 32'h0800_0004, 0, 0);
        put(0, 32'h0000_0004, 0, 0);
        run_phase("R2");
        @(negedge clk);
        boot_sel = 1'b0;
        put(0, 32'h0000_0004, 0, 0);
        run_phase("R3");
        do_reset(1'b0);

        // R4 R5: unreachable and unmapped addresses
        put(0, 32'h2000_0000, 0, 0);
        put(0, 32'h0800_0000, 0, 0);
        put(3, 32'h1000_0000, 0, 0);
        put(3, 32'hE000_0004, 1, 32'hDEAD_BEEF);
        put(1, 32'h3000_0000, 0, 0);
        put(1, 32'h4000_0000, 0, 0);
        put(2, 32'h9000_0000, 1, 32'h5555_5555);
        put(2, 32'hE000_0004, 0, 0);
        put(2, 32'h0800_0000, 0, 0);
        run_phase("R4 R5");

        // R6: per-slave latency, one access at a time
        put(1, 32'h0800_0000, 0, 0); run_phase("R6");
        put(1, 32'h1000_0000, 0, 0); run_phase("R6");
        put(2, 32'h2000_0000, 0, 0); run_phase("R6");
        put(2, 32'h4000_0000, 0, 0); run_phase("R6");
        put(2, 32'hE000_0000, 0, 0); run_phase("R6");
        put(0, 32'h0000_0000, 0, 0); run_phase("R6");

        // R7 R11: all four masters on different slaves together
        put(0, 32'h0800_0004, 0, 0);
        put(1, 32'h1000_0004, 1, 32'h0707_0707);
        put(2, 32'h4000_0004, 1, 32'h0404_0404);
        put(3, 32'h2000_0004, 1, 32'h0303_0303);
        put(0, 32'h0000_0008, 0, 0);
        put(1, 32'h1000_0004, 0, 0);
        put(2, 32'h2000_0004, 0, 0);
        put(3, 32'h4000_0004, 0, 0);
        run_phase("R7 R11");

        // R8 R9: contention on SRAM and on flash
        put(2, 32'h2000_0000, 1, 32'h0000_0011);
        put(2, 32'h2000_0004, 1, 32'h0000_0012);
        put(2, 32'h2000_0000, 0, 0);
        put(2, 32'h2000_0008, 0, 0);
        put(3, 32'h2000_0008, 1, 32'h0000_0021);
        put(3, 32'h2000_0000, 0, 0);
        put(3, 32'h2000_0008, 0, 0);
        put(3, 32'h2000_0004, 0, 0);
        put(0, 32'h0800_0010, 0, 0);
        put(0, 32'h0800_0014, 0, 0);
        put(0, 32'h0800_0010, 0, 0);
        put(1, 32'h0800_0014, 1, 32'h0000_0031);
        put(1, 32'h0800_0010, 1, 32'h0000_0032);
        put(1, 32'h0800_0014, 0, 0);
        run_phase("R8 R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule